// File: doc/BRIEF.md
# Bridge Fault Monitor and Flag Encoder

This block watches the two full bridges of a stepper-motor driver and folds their fault state into two active-low error lines. Each bridge has its own fault state. An open-load fault is inferred when a direction reversal is not followed by a recirculation pulse within a fixed window. A direction reversal made while the bridge is at holding current raises open load at once. A short to ground is latched from a per-bridge detect input, and after a programmable delay it turns on a drive-disable output for that bridge.

A temperature warning level is passed through a two-flop synchronizer and pulls both error lines low while it stays high. It is never latched. A short to ground takes priority over open load: while any short is latched, the load line stays high and only the ground line is pulled low. A bridge's fault state is cleared by a direction reversal on that bridge or by setting its current code to zero. When the driver leaves the all-off state, open load is raised on every bridge whose direction input is high. That flag is removed by the bridge's first recirculation pulse.

All control inputs are synchronous to `clk`. The current code of bridge i occupies bits [2i+1:2i] of `cur_code`. The code values are 00 off, 01 hold, 10 run and 11 boost.

Top module: `bridge_fault_monitor`

## Requirements
- R1: A direction reversal on a bridge whose code is 10 or 11 opens a window of RECIRC_WAIT cycles. If no recirculation pulse arrives in that window, the bridge's open-load flag is set on the edge after the window ends, and `err_load_n` goes low. It is still high RECIRC_WAIT cycles after the reversal.
- R2: A recirculation pulse that arrives during the window closes the window, and no open-load flag is raised.
- R3: A direction reversal while the bridge's code is 01 (hold) sets the open-load flag on the same edge.
- R4: While code is nonzero, a high `gnd_short` latches a short flag on the next edge. `err_gnd_n` then goes low. `err_load_n` is held high while any short is latched, whatever the open-load flags are.
- R5: `drive_off` of a bridge rises exactly SHORT_DLY cycles after its short flag is latched. It stays high until that bridge's fault state is cleared.
- R6: A direction reversal with a nonzero code clears the bridge's short flag, its `drive_off` and any earlier open-load flag.
- R7: Code 00 on a bridge clears all of its flags, and `gnd_short` has no effect while its code is 00.
- R8: On the first edge where some code becomes nonzero after all codes were 00, a bridge whose direction input is high gets its open-load flag set. Its next recirculation pulse clears that flag.
- R9: `temp_warn` reaches the outputs through two flops and pulls both error lines low. Both lines return high two cycles after `temp_warn` falls, unless a fault is present.
- R10: After reset both error lines are high and every `drive_off` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_dir | input | NUM_BR | Current direction per bridge |
| cur_code | input | 2*NUM_BR | Current magnitude code per bridge; bridge i uses bits [2i+1:2i] |
| recirc_pulse | input | NUM_BR | One-cycle pulse per bridge when recirculation is seen |
| gnd_short | input | NUM_BR | Short-to-ground detect level per bridge |
| temp_warn | input | 1 | Temperature prealarm level, asynchronous |
| err_load_n | output | 1 | Low on open load (when no short is latched) or on prealarm |
| err_gnd_n | output | 1 | Low on short to ground or on prealarm |
| drive_off | output | NUM_BR | Per-bridge request to cut the output current |

## Verification
The bench samples the window boundary on both sides of its last cycle. A counter that is off by one then moves the fall of `err_load_n` one cycle early or late. It counts the exact cycle on which `drive_off` rises and checks that the output stays high until a reversal arrives. A design that dropped the short-over-open priority would pull both lines low while an open load and a short are present together. The bench also covers a short input raised while the code is 00, a recirculation pulse inside the window, and leaving the all-off state with direction high. In the first case a design that ignored the off code would latch a short; in the other two, a missing flag or a flag that never clears shows at once. A long stretch of random stimulus follows, checked against a cycle-level reference model on every clock.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    CODE_OFF   = 2'b00,
    CODE_HOLD  = 2'b01,
    CODE_RUN   = 2'b10,
    CODE_BOOST = 2'b11
  } code_t;

  // True when the bridge requests no current at all.
  function automatic logic code_is_off(input logic [CODE_W-1:0] c);
    return c == CODE_OFF;
  endfunction

  // True when the bridge sits at holding current.
  function automatic logic code_is_hold(input logic [CODE_W-1:0] c);
    return c == CODE_HOLD;
  endfunction

  // Pin encoding: {load_n, gnd_n}; a short hides open load.
  function automatic logic [1:0] flags_to_pins(input logic any_open,
                                               input logic any_short,
                                               input logic warn);
    logic load_act;
    logic gnd_act;
    load_act = (any_open & ~any_short) | warn;
    gnd_act  = any_short | warn;
    return {~load_act, ~gnd_act};
  endfunction

endpackage

// File: rtl/bfm_sync.sv
module bfm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/bfm_inhibit.sv
module bfm_inhibit
  import bfm_pkg::*;
#(
  parameter int NUM_BR = 2,
  localparam int CODE_BITS = NUM_BR * CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_BITS-1:0] code_i,
  output logic                 wake_o
);

  logic [NUM_BR-1:0] br_off;
  logic              all_off;
  logic              inhib_q;

  generate
    for (genvar b = 0; b < NUM_BR; b++) begin : g_off
      assign br_off[b] = code_is_off(code_i[b*CODE_W +: CODE_W]);
    end
  endgenerate

  assign all_off = &br_off;

  // Starts in the inhibited state so the first enable counts as a wake.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inhib_q <= 1'b1;
    else        inhib_q <= all_off;
  end

  assign wake_o = inhib_q & ~all_off;

  AST_WAKE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> $past(all_off) || $past(!rst_n)); // R8

endmodule

// File: rtl/bfm_cell.sv
module bfm_cell
  import bfm_pkg::*;
#(
  parameter int RECIRC_WAIT = 1500,
  parameter int SHORT_DLY   = 3000,
  localparam int WIN_W = $clog2(RECIRC_WAIT + 1),
  localparam int SC_W  = $clog2(SHORT_DLY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              recirc_i,
  input  logic              short_i,
  input  logic              wake_i,
  output logic              open_o,
  output logic              short_o,
  output logic              off_o
);

  logic             dir_q;
  logic             open_f;
  logic             wake_f;
  logic             short_f;
  logic             off_f;
  logic [WIN_W-1:0] win_cnt;
  logic [SC_W-1:0]  sh_cnt;

  // Named events for the assertions.
  logic code_off;
  logic chg_evt;
  logic clr_evt;
  logic win_live;
  logic win_expire;
  logic wake_set;
  logic wake_clr;
  logic short_new;
  logic off_due;

  assign code_off   = code_is_off(code_i);
  assign chg_evt    = dir_i ^ dir_q;
  assign clr_evt    = code_off | chg_evt;
  assign win_live   = win_cnt != '0;
  assign win_expire = ~clr_evt & win_live & ~recirc_i & (win_cnt == WIN_W'(1));
  assign wake_set   = ~clr_evt & wake_i & dir_i;
  assign wake_clr   = ~clr_evt & ~wake_set & wake_f & recirc_i;
  assign short_new  = ~clr_evt & ~short_f & short_i;
  assign off_due    = ~clr_evt & short_f & ~off_f & (sh_cnt == SC_W'(SHORT_DLY - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_i;
  end

  // Recirculation window after a reversal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
    end else if (code_off) begin
      win_cnt <= '0;
    end else if (chg_evt) begin
      win_cnt <= code_is_hold(code_i) ? '0 : WIN_W'(RECIRC_WAIT);
    end else if (win_live) begin
      win_cnt <= recirc_i ? '0 : win_cnt - WIN_W'(1);
    end
  end

  // Open-load flag and the wake marker that lets recirculation clear it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_f <= 1'b0;
      wake_f <= 1'b0;
    end else if (code_off) begin
      open_f <= 1'b0;
      wake_f <= 1'b0;
    end else if (chg_evt) begin
      open_f <= code_is_hold(code_i);
      wake_f <= 1'b0;
    end else begin
      if (win_expire) open_f <= 1'b1;
      if (wake_set) begin
        open_f <= 1'b1;
        wake_f <= 1'b1;
      end else if (wake_clr) begin
        open_f <= 1'b0;
        wake_f <= 1'b0;
      end
    end
  end

  // Short-to-ground latch and disable delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_f <= 1'b0;
      off_f   <= 1'b0;
      sh_cnt  <= '0;
    end else if (clr_evt) begin
      short_f <= 1'b0;
      off_f   <= 1'b0;
      sh_cnt  <= '0;
    end else if (short_new) begin
      short_f <= 1'b1;
      sh_cnt  <= '0;
    end else if (off_due) begin
      off_f <= 1'b1;
    end else if (short_f && !off_f) begin
      sh_cnt <= sh_cnt + SC_W'(1);
    end
  end

  assign open_o  = open_f;
  assign short_o = short_f;
  assign off_o   = off_f;

  AST_WINDOW_EXPIRES: assert property (@(posedge clk) disable iff (!rst_n)
    win_expire |=> open_f); // R1
  AST_RECIRC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_live && recirc_i && !clr_evt) |=> !win_live); // R2
  AST_HOLD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_evt && code_is_hold(code_i)) |=> open_f); // R3
  AST_OFF_NEEDS_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    off_f |-> short_f); // R5
  AST_OFF_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (off_f && !clr_evt) |=> off_f); // R5
  AST_FLIP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_evt && !code_off) |=> (!off_f && !short_f)); // R6
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    code_off |=> (!open_f && !short_f && !off_f)); // R7
  AST_WAKE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> open_f); // R8

endmodule

// File: rtl/bfm_encoder.sv
module bfm_encoder
  import bfm_pkg::*;
#(
  parameter int NUM_BR = 2
) (
  input  logic [NUM_BR-1:0] open_vec,
  input  logic [NUM_BR-1:0] short_vec,
  input  logic              warn_i,
  output logic              load_n_o,
  output logic              gnd_n_o
);

  logic [1:0] pins;

  assign pins     = flags_to_pins(|open_vec, |short_vec, warn_i);
  assign load_n_o = pins[1];
  assign gnd_n_o  = pins[0];

endmodule

// File: rtl/bridge_fault_monitor.sv
module bridge_fault_monitor
  import bfm_pkg::*;
#(
  parameter int NUM_BR      = 2,
  parameter int RECIRC_WAIT = 1500,
  parameter int SHORT_DLY   = 3000,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_BITS  = NUM_BR * CODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BR-1:0]    phase_dir,
  input  logic [CODE_BITS-1:0] cur_code,
  input  logic [NUM_BR-1:0]    recirc_pulse,
  input  logic [NUM_BR-1:0]    gnd_short,
  input  logic                 temp_warn,
  output logic                 err_load_n,
  output logic                 err_gnd_n,
  output logic [NUM_BR-1:0]    drive_off
);

  logic              warn_s;
  logic              wake;
  logic [NUM_BR-1:0] open_vec;
  logic [NUM_BR-1:0] short_vec;

  bfm_sync #(.STAGES(SYNC_STAGES)) u_warn_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (temp_warn),
    .sync_o  (warn_s)
  );

  bfm_inhibit #(.NUM_BR(NUM_BR)) u_inhibit (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (cur_code),
    .wake_o (wake)
  );

  generate
    for (genvar b = 0; b < NUM_BR; b++) begin : g_br
      bfm_cell #(
        .RECIRC_WAIT (RECIRC_WAIT),
        .SHORT_DLY   (SHORT_DLY)
      ) u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_i    (phase_dir[b]),
        .code_i   (cur_code[b*CODE_W +: CODE_W]),
        .recirc_i (recirc_pulse[b]),
        .short_i  (gnd_short[b]),
        .wake_i   (wake),
        .open_o   (open_vec[b]),
        .short_o  (short_vec[b]),
        .off_o    (drive_off[b])
      );
    end
  endgenerate

  bfm_encoder #(.NUM_BR(NUM_BR)) u_enc (
    .open_vec  (open_vec),
    .short_vec (short_vec),
    .warn_i    (warn_s),
    .load_n_o  (err_load_n),
    .gnd_n_o   (err_gnd_n)
  );

  AST_GND_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    (|short_vec && !warn_s) |-> (err_load_n && !err_gnd_n)); // R4
  AST_WARN_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    warn_s |-> (!err_load_n && !err_gnd_n)); // R9
  AST_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|short_vec) && !(|open_vec) && !warn_s) |-> (err_load_n && err_gnd_n)); // R10

endmodule

// File: tb/bridge_fault_monitor_bench.sv
`timescale 1ns/1ps
module bridge_fault_monitor_bench;

  localparam int NB = 2;
  localparam int W  = 6;
  localparam int D  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NB-1:0] phase_dir = '0;
  logic [3:0]    cur_code = '0;
  logic [NB-1:0] recirc_pulse = '0;
  logic [NB-1:0] gnd_short = '0;
  logic          temp_warn = 1'b0;
  logic          err_load_n;
  logic          err_gnd_n;
  logic [NB-1:0] drive_off;

  always #2.5 clk = ~clk;

  bridge_fault_monitor #(
    .NUM_BR(NB), .RECIRC_WAIT(W), .SHORT_DLY(D)
  ) u_bridge_fault_monitor (
    .clk(clk), .rst_n(rst_n), .phase_dir(phase_dir), .cur_code(cur_code),
    .recirc_pulse(recirc_pulse), .gnd_short(gnd_short), .temp_warn(temp_warn),
    .err_load_n(err_load_n), .err_gnd_n(err_gnd_n), .drive_off(drive_off)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R10";

  // Reference model state, one entry per bridge.
  int m_dir[NB], m_open[NB], m_wk[NB], m_sh[NB], m_off[NB], m_win[NB], m_cnt[NB];
  int m_idle = 1;
  int m_p1 = 0, m_p2 = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_load();
    int o = 0, s = 0;
    for (int b = 0; b < NB; b++) begin o |= m_open[b]; s |= m_sh[b]; end
    if (m_p2 != 0) return 0;
    return (o != 0 && s == 0) ? 0 : 1;
  endfunction

  function automatic int exp_gnd();
    int s = 0;
    for (int b = 0; b < NB; b++) s |= m_sh[b];
    return (s != 0 || m_p2 != 0) ? 0 : 1;
  endfunction

  function automatic int exp_off(int b);
    return m_off[b];
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_dir[b] = 0; m_open[b] = 0; m_wk[b] = 0; m_sh[b] = 0;
      m_off[b] = 0; m_win[b] = 0; m_cnt[b] = 0;
    end
    m_idle = 1; m_p1 = 0; m_p2 = 0;
  endtask

  task automatic model_bridge(int b, int wake);
    int cd, d, r, s;
    cd = (cur_code >> (2*b)) & 3;
    d  = phase_dir[b]; r = recirc_pulse[b]; s = gnd_short[b];
    if (cd == 0) begin
      m_open[b] = 0; m_wk[b] = 0; m_sh[b] = 0; m_off[b] = 0; m_win[b] = 0; m_cnt[b] = 0;
    end else if (d != m_dir[b]) begin
      m_sh[b] = 0; m_off[b] = 0; m_cnt[b] = 0; m_wk[b] = 0;
      m_open[b] = (cd == 1) ? 1 : 0;
      m_win[b]  = (cd == 1) ? 0 : W;
    end else begin
      if (m_win[b] > 0) begin
        if (r != 0) m_win[b] = 0;
        else if (m_win[b] == 1) begin m_open[b] = 1; m_win[b] = 0; end
        else m_win[b]--;
      end
      if (wake != 0 && d != 0) begin m_open[b] = 1; m_wk[b] = 1; end
      else if (m_wk[b] != 0 && r != 0) begin m_open[b] = 0; m_wk[b] = 0; end
      if (m_sh[b] != 0) begin
        if (m_off[b] == 0) begin
          if (m_cnt[b] == D - 1) m_off[b] = 1;
          else m_cnt[b]++;
        end
      end else if (s != 0) begin
        m_sh[b] = 1; m_cnt[b] = 0;
      end
    end
    m_dir[b] = d;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model_reset();
    else begin
      int wake;
      wake = (m_idle != 0 && cur_code != 0) ? 1 : 0;
      for (int b = 0; b < NB; b++) model_bridge(b, wake);
      m_idle = (cur_code == 0) ? 1 : 0;
      m_p2 = m_p1; m_p1 = temp_warn;
    end
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " load_n"}, err_load_n, exp_load());
      chk({cur_req, " gnd_n"}, err_gnd_n, exp_gnd());
      for (int b = 0; b < NB; b++) chk({cur_req, " drive_off"}, drive_off[b], exp_off(b));
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_recirc(int b);
    recirc_pulse[b] = 1'b1;
    step(1);
    recirc_pulse[b] = 1'b0;
  endtask

  initial begin
    model_reset();
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk("R10", err_load_n, 1); chk("R10", err_gnd_n, 1); chk("R10", drive_off, 0);

    // R1: reversal at run code, no recirculation
    cur_req = "R1";
    cur_code = 4'b1010; step(2);
    phase_dir[0] = 1'b1; step(W);
    chk("R1 before end", err_load_n, 1);
    step(1);
    chk("R1 expired", err_load_n, 0);

    // R6 then R2
    cur_req = "R6";
    phase_dir[0] = 1'b0; step(1);
    chk("R6 reversal clears", err_load_n, 1);
    cur_req = "R2";
    step(1); pulse_recirc(0); step(W + 2);
    chk("R2 recirc in window", err_load_n, 1);

    // R3: reversal at hold
    cur_req = "R3";
    cur_code[1:0] = 2'b01; phase_dir[0] = 1'b1; step(1);
    chk("R3 hold reversal", err_load_n, 0);

    // R7: code off clears and masks short
    cur_req = "R7";
    cur_code[1:0] = 2'b00; step(1);
    chk("R7 clear", err_load_n, 1);
    gnd_short[0] = 1'b1; step(3);
    chk("R7 short ignored", err_gnd_n, 1);
    chk("R7 no disable", drive_off[0], 0);
    gnd_short[0] = 1'b0;

    // R4: short dominates open load on other bridge
    cur_req = "R4";
    cur_code[1:0] = 2'b10; step(1);
    cur_code[3:2] = 2'b01; phase_dir[1] = 1'b1; step(1);
    chk("R4 open on bridge1", err_load_n, 0);
    gnd_short[0] = 1'b1; step(1);
    gnd_short[0] = 1'b0;
    chk("R4 gnd low", err_gnd_n, 0);
    chk("R4 load masked", err_load_n, 1);

    // R5: disable timing
    cur_req = "R5";
    step(D - 1);
    chk("R5 not yet", drive_off[0], 0);
    step(1);
    chk("R5 asserted", drive_off[0], 1);
    step(5);
    chk("R5 held", drive_off[0], 1);
    chk("R5 other bridge", drive_off[1], 0);

    // R6: reversal releases disable
    cur_req = "R6";
    phase_dir[0] = 1'b0; step(1);
    chk("R6 disable cleared", drive_off[0], 0);
    chk("R6 gnd high", err_gnd_n, 1);
    chk("R6 bridge1 open shows", err_load_n, 0);

    // R8: leaving the all-off state with direction high
    cur_req = "R8";
    cur_code = 4'b0000; step(2);
    phase_dir[0] = 1'b1; step(1);
    chk("R8 idle", err_load_n, 1);
    cur_code[1:0] = 2'b11; step(1);
    chk("R8 wake flag", err_load_n, 0);
    pulse_recirc(0);
    chk("R8 recirc clears", err_load_n, 1);

    // R9: prealarm pass-through
    cur_req = "R9";
    temp_warn = 1'b1; step(1);
    chk("R9 one stage", err_gnd_n, 1);
    step(1);
    chk("R9 load low", err_load_n, 0);
    chk("R9 gnd low", err_gnd_n, 0);
    temp_warn = 1'b0; step(2);
    chk("R9 released load", err_load_n, 1);
    chk("R9 released gnd", err_gnd_n, 1);

    // Random stretch checked by the model (R1 windows, R5 delays, R4 priority)
    cur_req = "R1 random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) phase_dir = NB'($urandom);
      if ($urandom_range(0, 19) == 0) cur_code = 4'($urandom);
      recirc_pulse = ($urandom_range(0, 7) == 0) ? NB'($urandom) : '0;
      gnd_short = ($urandom_range(0, 29) == 0) ? NB'($urandom) : '0;
      if ($urandom_range(0, 99) == 0) temp_warn = ~temp_warn;
      step(1);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule